// File: doc/BRIEF.md
# Dual-Slot In-Order Dispatch Controller

This block sits between an instruction fetch path and the issue queues of an out-of-order core. It holds up to six instructions that are already decoded and are not branches, in program order. A fetch port can deliver up to four of them per cycle. Each cycle the controller looks at the two oldest entries. For each one it decides whether it can leave now and where it goes: into its execution unit's reservation station, or straight into the unit. An instruction can go straight to the unit only when its operands are already available, the unit can accept it this cycle and no older instruction is waiting in that unit's station. Branches never enter this queue, because the branch path handles them.

Before it sends anything, the controller checks station space, unit slots, free completion-queue entries and free rename registers. When two instructions leave in the same cycle it counts their combined demand. It reports how many completion entries and rename registers of each class to allocate. The external allocators own the free counts. They also restore those counts on a flush, which empties this queue.

Each instruction word is packed from the most significant bit down: unit code (2 bits), operand-ready flag (1 bit), destination mask (5 bits) and an opaque tag (8 bits). Unit codes are 0 for simple integer, 1 for complex integer, 2 for floating point and 3 for load/store.

Top module: `dispatch_ctrl`

## Requirements
- R1: The queue holds at most 6 entries. In a cycle, fetch takes the smaller of `fetch_cnt` and the room, where the room is 6 minus the occupancy plus the number dispatched that cycle. `fetch_room` reports the room and `fetch_take` the count taken, and the taken instructions are appended behind the ones that remain.
- R2: Dispatch slot 0 carries the oldest entry and slot 1 the next one. Dispatched entries leave the queue and the remaining entries move up in order, so instructions leave in fetch order.
- R3: Slot 1 never dispatches in a cycle where slot 0 does not.
- R4: Routing into a reservation station needs its occupancy (`unit_occ`, 2 bits per unit, unit u at bits [2u+1:2u]) to be below its depth. The depth is 2 for unit 3 and 1 for units 0 to 2. When both slots go to the same unit's station, they need two free entries.
- R5: An instruction goes directly to its unit, shown by `disp_direct`, when its ready flag is set, `unit_slot[u]` is 1 and the unit's occupancy is 0. Direct routing is chosen whenever it is possible. If slot 0 goes direct, a slot 1 instruction for the same unit must use the station.
- R6: Each dispatched instruction needs one completion entry. The number dispatched never exceeds `cq_free`, and `cq_alloc` equals that number.
- R7: Destination mask bit 0 is a general register, bit 1 a floating-point register, bit 2 the condition register, bit 3 the link register and bit 4 the count register. For each class, the combined demand of the dispatching instructions must fit that class's free count. The `*_alloc` outputs equal the summed demand.
- R8: While `flush` is high, nothing dispatches and fetch takes nothing. In the next cycle the queue is empty.
- R9: After reset the queue is empty, `fetch_room` is 6 and `disp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue, block dispatch and fetch |
| fetch_cnt | input | 3 | Number of valid words offered on `fetch_bus` |
| fetch_bus | input | 64 | Four instruction words, word 0 (oldest) in the low bits |
| fetch_room | output | 3 | Entries fetch may fill this cycle |
| fetch_take | output | 3 | Entries fetch fills this cycle |
| unit_occ | input | 8 | Reservation station occupancy, 2 bits per unit |
| unit_slot | input | 4 | Unit can take an instruction directly this cycle |
| cq_free | input | 3 | Free completion-queue entries |
| gpr_free | input | 3 | Free general rename registers |
| fpr_free | input | 3 | Free floating-point rename registers |
| cr_free | input | 1 | Condition rename register free |
| lr_free | input | 1 | Link rename register free |
| ctr_free | input | 1 | Count rename register free |
| disp_valid | output | 2 | Slot dispatches this cycle |
| disp_direct | output | 2 | Slot goes straight to its unit |
| disp_bus | output | 32 | Slot 0 word in the low half, slot 1 word in the high half |
| cq_alloc | output | 2 | Completion entries to allocate |
| gpr_alloc | output | 2 | General rename registers to allocate |
| fpr_alloc | output | 2 | Floating-point rename registers to allocate |
| cr_alloc | output | 2 | Condition rename registers to allocate |
| lr_alloc | output | 2 | Link rename registers to allocate |
| ctr_alloc | output | 2 | Count rename registers to allocate |

## Verification
The assertions take for granted that `fetch_cnt` never exceeds 4, that no station reports an occupancy above its depth, and that each free count stays within the size of its resource. The bench only drives values inside those limits. When it sweeps the pairs of instruction words at the queue head, it holds `cq_free` at zero while the pair is loaded and again at every clock edge. Many resource settings are then applied and checked between two edges, so the queue contents stay the same for the whole sweep of that pair.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int NUNITS   = 4;
    localparam int UW       = 2;
    localparam int TAG_W    = 8;
    localparam int DST_W    = 5;
    localparam int INSTR_W  = UW + 1 + DST_W + TAG_W;
    localparam int LSU_UNIT = 3;
    localparam int DST_GPR  = 0;
    localparam int DST_FPR  = 1;
    localparam int DST_CR   = 2;
    localparam int DST_LR   = 3;
    localparam int DST_CTR  = 4;

    typedef struct packed {
        logic [UW-1:0]    unit;
        logic             ready;
        logic [DST_W-1:0] dst;
        logic [TAG_W-1:0] tag;
    } instr_t;
endpackage

// File: rtl/dq_store.sv
module dq_store
    import dq_pkg::*;
#(
    parameter int DEPTH   = 6,
    parameter int FETCH_W = 4,
    parameter int CW      = 3,
    parameter int FW      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [1:0]            n_disp,
    input  logic [FW-1:0]         fetch_cnt,
    input  instr_t [FETCH_W-1:0]  fetch_data,
    output instr_t                head0,
    output instr_t                head1,
    output logic [CW-1:0]         cnt,
    output logic [CW-1:0]         room,
    output logic [FW-1:0]         take
);
    typedef struct packed {
        instr_t [DEPTH-1:0] ent;
        logic [CW-1:0]      cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        int keep_v, room_v, take_v;
        st_d   = st_q;
        keep_v = int'(st_q.cnt) - int'(n_disp);
        room_v = DEPTH - keep_v;
        take_v = (int'(fetch_cnt) < room_v) ? int'(fetch_cnt) : room_v;
        if (take_v > FETCH_W) take_v = FETCH_W;
        if (flush) take_v = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i + int'(n_disp) < DEPTH) st_d.ent[i] = st_q.ent[i + int'(n_disp)];
        end
        for (int j = 0; j < FETCH_W; j++) begin
            if (j < take_v && keep_v + j < DEPTH) st_d.ent[keep_v + j] = fetch_data[j];
        end
        st_d.cnt = flush ? '0 : CW'(keep_v + take_v);
        room     = CW'(room_v);
        take     = FW'(take_v);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head0 = st_q.ent[0];
    assign head1 = st_q.ent[1];
    assign cnt   = st_q.cnt;

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) <= DEPTH);
    assert_drain_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (n_disp == 2'd2) |-> (int'(st_q.cnt) >= 2));
    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0));
endmodule

// File: rtl/dq_route.sv
module dq_route
    import dq_pkg::*;
#(
    parameter int CW = 3,
    parameter int RW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [CW-1:0]         qcnt,
    input  logic [UW-1:0]         u0,
    input  logic [UW-1:0]         u1,
    input  logic                  rdy0,
    input  logic                  rdy1,
    input  logic [DST_W-1:0]      dst0,
    input  logic [DST_W-1:0]      dst1,
    input  logic [2*NUNITS-1:0]   unit_occ,
    input  logic [NUNITS-1:0]     unit_slot,
    input  logic [CW-1:0]         cq_free,
    input  logic [RW-1:0]         gpr_free,
    input  logic [RW-1:0]         fpr_free,
    input  logic                  cr_free,
    input  logic                  lr_free,
    input  logic                  ctr_free,
    output logic [1:0]            go,
    output logic [1:0]            dir,
    output logic [1:0]            cq_alloc,
    output logic [1:0]            gpr_alloc,
    output logic [1:0]            fpr_alloc,
    output logic [1:0]            cr_alloc,
    output logic [1:0]            lr_alloc,
    output logic [1:0]            ctr_alloc
);
    logic [1:0] occ0, occ1, dep0, dep1;
    logic       dir0, dir1, stn0, stn1, res0, res1;
    logic [1:0] n_gpr, n_fpr, n_cr, n_lr, n_ctr;

    always_comb begin
        occ0  = unit_occ[int'(u0)*2 +: 2];
        occ1  = unit_occ[int'(u1)*2 +: 2];
        dep0  = (int'(u0) == LSU_UNIT) ? 2'd2 : 2'd1;
        dep1  = (int'(u1) == LSU_UNIT) ? 2'd2 : 2'd1;
        n_gpr = {1'b0, dst0[DST_GPR]} + {1'b0, dst1[DST_GPR]};
        n_fpr = {1'b0, dst0[DST_FPR]} + {1'b0, dst1[DST_FPR]};
        n_cr  = {1'b0, dst0[DST_CR]}  + {1'b0, dst1[DST_CR]};
        n_lr  = {1'b0, dst0[DST_LR]}  + {1'b0, dst1[DST_LR]};
        n_ctr = {1'b0, dst0[DST_CTR]} + {1'b0, dst1[DST_CTR]};

        dir0 = rdy0 && unit_slot[u0] && (occ0 == 2'd0);
        stn0 = occ0 < dep0;
        res0 = (cq_free != '0)
            && (gpr_free >= RW'(dst0[DST_GPR])) && (fpr_free >= RW'(dst0[DST_FPR]))
            && (cr_free || !dst0[DST_CR]) && (lr_free || !dst0[DST_LR])
            && (ctr_free || !dst0[DST_CTR]);

        if (u1 == u0) begin
            dir1 = 1'b0;
            stn1 = dir0 ? 1'b1 : (({1'b0, occ1} + 3'd1) < {1'b0, dep1});
        end else begin
            dir1 = rdy1 && unit_slot[u1] && (occ1 == 2'd0);
            stn1 = occ1 < dep1;
        end
        res1 = (int'(cq_free) >= 2)
            && (gpr_free >= RW'(n_gpr)) && (fpr_free >= RW'(n_fpr))
            && ({1'b0, cr_free} >= n_cr) && ({1'b0, lr_free} >= n_lr)
            && ({1'b0, ctr_free} >= n_ctr);

        go[0] = (qcnt != '0) && !flush && (dir0 || stn0) && res0;
        go[1] = go[0] && (int'(qcnt) >= 2) && (dir1 || stn1) && res1;
        dir   = {go[1] & dir1, go[0] & dir0};

        cq_alloc  = {1'b0, go[0]} + {1'b0, go[1]};
        gpr_alloc = {1'b0, go[0] & dst0[DST_GPR]} + {1'b0, go[1] & dst1[DST_GPR]};
        fpr_alloc = {1'b0, go[0] & dst0[DST_FPR]} + {1'b0, go[1] & dst1[DST_FPR]};
        cr_alloc  = {1'b0, go[0] & dst0[DST_CR]}  + {1'b0, go[1] & dst1[DST_CR]};
        lr_alloc  = {1'b0, go[0] & dst0[DST_LR]}  + {1'b0, go[1] & dst1[DST_LR]};
        ctr_alloc = {1'b0, go[0] & dst0[DST_CTR]} + {1'b0, go[1] & dst1[DST_CTR]};
    end

    assert_cq_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(cq_alloc) <= cq_free);
    assert_gpr_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        RW'(gpr_alloc) <= gpr_free);
    assert_fpr_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        RW'(fpr_alloc) <= fpr_free);
    assert_direct_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dir[0] |-> (unit_slot[u0] && rdy0 && occ0 == 2'd0));
    assert_station_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (go[0] && !dir[0]) |-> (occ0 < dep0));
endmodule

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
    import dq_pkg::*;
#(
    parameter int DEPTH   = 6,
    parameter int FETCH_W = 4,
    parameter int REN_N   = 6,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int FW     = $clog2(FETCH_W + 1),
    localparam int RW     = $clog2(REN_N + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic [FW-1:0]               fetch_cnt,
    input  logic [FETCH_W*INSTR_W-1:0]  fetch_bus,
    output logic [CW-1:0]               fetch_room,
    output logic [FW-1:0]               fetch_take,
    input  logic [2*NUNITS-1:0]         unit_occ,
    input  logic [NUNITS-1:0]           unit_slot,
    input  logic [CW-1:0]               cq_free,
    input  logic [RW-1:0]               gpr_free,
    input  logic [RW-1:0]               fpr_free,
    input  logic                        cr_free,
    input  logic                        lr_free,
    input  logic                        ctr_free,
    output logic [1:0]                  disp_valid,
    output logic [1:0]                  disp_direct,
    output logic [2*INSTR_W-1:0]        disp_bus,
    output logic [1:0]                  cq_alloc,
    output logic [1:0]                  gpr_alloc,
    output logic [1:0]                  fpr_alloc,
    output logic [1:0]                  cr_alloc,
    output logic [1:0]                  lr_alloc,
    output logic [1:0]                  ctr_alloc
);
    instr_t [FETCH_W-1:0] fetch_data;
    instr_t               head0, head1;
    logic [CW-1:0]        qcnt;
    logic [1:0]           go, n_disp;

    for (genvar j = 0; j < FETCH_W; j++) begin : g_unpack
        assign fetch_data[j] = instr_t'(fetch_bus[j*INSTR_W +: INSTR_W]);
    end

    assign n_disp = {1'b0, go[0]} + {1'b0, go[1]};

    dq_store #(.DEPTH(DEPTH), .FETCH_W(FETCH_W), .CW(CW), .FW(FW)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .n_disp(n_disp),
        .fetch_cnt(fetch_cnt), .fetch_data(fetch_data),
        .head0(head0), .head1(head1), .cnt(qcnt),
        .room(fetch_room), .take(fetch_take)
    );

    dq_route #(.CW(CW), .RW(RW)) u_route (
        .clk(clk), .rst_n(rst_n), .flush(flush), .qcnt(qcnt),
        .u0(head0.unit), .u1(head1.unit), .rdy0(head0.ready), .rdy1(head1.ready),
        .dst0(head0.dst), .dst1(head1.dst),
        .unit_occ(unit_occ), .unit_slot(unit_slot), .cq_free(cq_free),
        .gpr_free(gpr_free), .fpr_free(fpr_free), .cr_free(cr_free),
        .lr_free(lr_free), .ctr_free(ctr_free),
        .go(go), .dir(disp_direct), .cq_alloc(cq_alloc),
        .gpr_alloc(gpr_alloc), .fpr_alloc(fpr_alloc), .cr_alloc(cr_alloc),
        .lr_alloc(lr_alloc), .ctr_alloc(ctr_alloc)
    );

    assign disp_valid = go;
    assign disp_bus   = {head1, head0};

    assert_no_orphan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid[1] |-> (int'(qcnt) >= 2 && disp_valid[0]));
    assert_no_overfill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fetch_take) <= int'(fetch_room));
endmodule

// File: tb/tb_dispatch_ctrl.sv
`timescale 1ns/1ps
module tb_dispatch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [2:0]  fetch_cnt = '0;
    logic [63:0] fetch_bus = '0;
    logic [2:0]  fetch_room, fetch_take;
    logic [7:0]  unit_occ = '0;
    logic [3:0]  unit_slot = '0;
    logic [2:0]  cq_free = '0, gpr_free = '0, fpr_free = '0;
    logic        cr_free = 1'b0, lr_free = 1'b0, ctr_free = 1'b0;
    logic [1:0]  disp_valid, disp_direct;
    logic [31:0] disp_bus;
    logic [1:0]  cq_alloc, gpr_alloc, fpr_alloc, cr_alloc, lr_alloc, ctr_alloc;

    int checks = 0, fails = 0, cycles = 0;

    dispatch_ctrl dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [15:0] mk(int unit, int rdy, int dst, int tag);
        return {unit[1:0], rdy[0], dst[4:0], tag[7:0]};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int occ_of(int u, int k);
        if (u == 3) return k;
        return (k > 1) ? 1 : k;
    endfunction

    // Expected result from the requirements: bits[1:0] valid, [3:2] direct, [5:4] gpr alloc, [7:6] cq alloc
    function automatic int model(int u0, int r0, int d0, int u1, int r1, int d1,
                                 int k, int slot, int cq, int gpr);
        int o0 = occ_of(u0, k), o1 = occ_of(u1, k);
        int p0 = (u0 == 3) ? 2 : 1, p1 = (u1 == 3) ? 2 : 1;
        int g0 = d0 & 1, g1 = d1 & 1, f0 = (d0 >> 1) & 1, f1 = (d1 >> 1) & 1;
        int c0 = (d0 >> 2) & 1, c1 = (d1 >> 2) & 1;
        bit x0, x1, ok0, ok1, s1;
        x0  = r0 && ((slot >> u0) & 1) && o0 == 0;
        ok0 = (x0 || o0 < p0) && cq >= 1 && gpr >= g0 && 1 >= f0 && 1 >= c0;
        if (u1 == u0) begin
            x1 = 0;
            s1 = x0 ? 1 : (o0 + 1 < p0);
        end else begin
            x1 = r1 && ((slot >> u1) & 1) && o1 == 0;
            s1 = x1 || o1 < p1;
        end
        ok1 = ok0 && s1 && cq >= 2 && gpr >= g0 + g1 && 1 >= f0 + f1 && 1 >= c0 + c1;
        return int'(ok0) | (int'(ok1) << 1) | (int'(ok0 && x0) << 2) | (int'(ok1 && x1) << 3)
             | ((ok0 ? g0 : 0) + (ok1 ? g1 : 0)) << 4 | (int'(ok0) + int'(ok1)) << 6;
    endfunction

    initial begin
        int dsts[4] = '{0, 1, 2, 5};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R9 reset state
        chk("R9 room", fetch_room, 6);
        chk("R9 valid", disp_valid, 0);

        // R1 fill with no completion entries
        lr_free = 1; ctr_free = 1; cr_free = 1;
        for (int t = 1; t <= 4; t++) fetch_bus[(t-1)*16 +: 16] = mk((t-1) % 2, 1, 0, t);
        fetch_cnt = 4;
        #1 chk("R1 take first", fetch_take, 4);
        step();
        chk("R1 room after four", fetch_room, 2);
        for (int t = 5; t <= 8; t++) fetch_bus[(t-5)*16 +: 16] = mk((t-1) % 2, 1, 0, t);
        #1 chk("R1 take truncated", fetch_take, 2);
        step();
        fetch_cnt = 0;
        #1 chk("R1 room full", fetch_room, 0);

        // R2/R5 drain in order, two per cycle, direct
        unit_slot = 4'hF; cq_free = 6; gpr_free = 6; fpr_free = 6;
        #1 chk("R1 room counts dispatch", fetch_room, 2);
        for (int c = 0; c < 3; c++) begin
            chk("R2 both slots", disp_valid, 3);
            chk("R5 direct both", disp_direct, 3);
            chk("R2 slot0 tag", disp_bus[7:0], 2*c + 1);
            chk("R2 slot1 tag", disp_bus[23:16], 2*c + 2);
            chk("R6 cq alloc", cq_alloc, 2);
            step();
        end
        chk("R2 drained", disp_valid, 0);
        chk("R2 room empty", fetch_room, 6);

        // R8 flush
        cq_free = 0;
        fetch_cnt = 3;
        step();
        fetch_cnt = 2; flush = 1; cq_free = 6;
        #1 chk("R8 no dispatch", disp_valid, 0);
        chk("R8 no fetch", fetch_take, 0);
        step();
        flush = 0; fetch_cnt = 0;
        #1 chk("R8 empty after", fetch_room, 6);
        chk("R8 nothing left", disp_valid, 0);

        // R3..R7 sweep over head pairs and resource levels
        for (int u0 = 0; u0 < 4; u0++)
        for (int u1 = 0; u1 < 4; u1++)
        for (int r = 0; r < 4; r++)
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
            cq_free = 0;
            fpr_free = 1;
            fetch_bus[15:0]  = mk(u0, r & 1, dsts[a], 8'h10);
            fetch_bus[31:16] = mk(u1, r >> 1, dsts[b], 8'h20);
            fetch_cnt = 2;
            step();
            fetch_cnt = 0;
            for (int cq = 0; cq < 3; cq++)
            for (int g = 0; g < 3; g++)
            for (int k = 0; k < 3; k++)
            for (int s = 0; s < 16; s++) begin
                int e;
                cq_free = cq[2:0]; gpr_free = g[2:0]; unit_slot = s[3:0];
                for (int u = 0; u < 4; u++) unit_occ[u*2 +: 2] = occ_of(u, k);
                #0.01;
                e = model(u0, r & 1, dsts[a], u1, r >> 1, dsts[b], k, s, cq, g);
                chk("R3 R4 valid", disp_valid, e & 3);
                chk("R5 direct", disp_direct, (e >> 2) & 3);
                chk("R7 gpr alloc", gpr_alloc, (e >> 4) & 3);
                chk("R6 cq alloc", cq_alloc, (e >> 6) & 3);
            end
            cq_free = 0;
            flush = 1;
            step();
            flush = 0;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule